// File: doc/BRIEF.md
# Multi-Channel Shared-RAM Mailbox Engine

This engine sits on the host side of a link to a co-processor. The two sides share a byte-wide RAM. The RAM holds a fixed-size message buffer for each channel and direction, plus one state byte for each buffer. There are seven channels. Each channel has an outbound mailbox and an inbound mailbox, and each mailbox holds exactly one message. Both sides step a mailbox through the same four-state handshake. The roles of the two sides are swapped between the outbound and inbound directions. A reply always goes back into the buffer that held the original message.

On the outbound side, the host hands the engine one 32-byte message for a channel. The engine keeps the message in a per-channel holding register until the outbound mailbox of that channel is free. It then copies the message into RAM, marks the mailbox, and rings a doorbell to the co-processor. When the co-processor signals that outbound work has finished, the engine sweeps the channels. For each finished mailbox it hands the reply back to the host and frees the mailbox.

On the inbound side, a notification from the co-processor starts a sweep for fresh messages. A channel whose consumer has claimed it gets the message and supplies a reply, which the engine writes back. A channel that no consumer has claimed is acknowledged at once, so that the co-processor never stalls.

Top module: `mbx_engine`

## Requirements
- R1: While reset is held and right after it, `doorbell`, `replyValid`, `rxValid` and `ramWe` are low, and `sendBusy` is low for any valid channel.
- R2: Starting a send on channel c writes byte i of `sendData` (bits 8i+7..8i) to address SEND_BUF_BASE + 32c + i for i = 0..31. It then writes 1 (NEW) to the state byte at SEND_STATE_BASE + c. `doorbell` is high for one cycle right after that state write.
- R3: After a pulse on `irqSendDone`, every channel whose outbound state byte reads 3 (COMPLETE) has its 32 bytes read back. For a channel with a message in flight, they appear on `replyData` with `replyValid` high for one cycle and `replyChan` = c. The engine then writes 0 (IDLE) to that state byte.
- R4: A held message is copied out only if the outbound state byte of its channel reads 0 when the engine checks it. If the byte reads anything else, the message stays held. It is then sent immediately after the IDLE write that ends the next completion on that channel.
- R5: Each channel holds at most one message. `sendBusy` is high while the holding register of the channel on `sendChan` is full, or when `sendChan` is 7 or higher. A request made while `sendBusy` is high is ignored.
- R6: A sweep visits channels in ascending order. The engine finishes all RAM traffic for one channel before it touches the next.
- R7: After a pulse on `irqRecvNew`, every channel whose inbound state byte reads 1 (NEW) is copied out and gets 2 (RCVD) written to its state byte. If `rxClaim[c]` is set, `rxValid` pulses with the message, and the engine waits for `rxReplyValid`. It then writes `rxReplyData` to RECV_BUF_BASE + 32c + i, writes 3 (COMPLETE) to the state byte, and rings the doorbell.
- R8: An inbound message on a channel whose `rxClaim` bit is clear produces no `rxValid`. The engine writes COMPLETE and rings the doorbell, and it leaves the buffer untouched.
- R9: The engine never writes IDLE to an inbound state byte. Returning an inbound mailbox to IDLE is left to the co-processor.
- R10: When both notifications are pending, the outbound sweep runs to the end before the inbound sweep begins.
- R11: A COMPLETE outbound state byte on a channel with no message in flight is still reset to IDLE, but no reply is reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| sendValid | input | 1 | Host offers a message |
| sendChan | input | 3 | Channel of the offered message |
| sendData | input | 256 | Offered message, byte i in bits 8i+7..8i |
| sendBusy | output | 1 | Holding register of `sendChan` full, or channel invalid |
| replyValid | output | 1 | One-cycle pulse: outbound reply available |
| replyChan | output | 3 | Channel of the reply |
| replyData | output | 256 | Reply bytes |
| rxClaim | input | 7 | Per-channel consumer present |
| rxValid | output | 1 | One-cycle pulse: inbound message for a claimed channel |
| rxChan | output | 3 | Channel of the inbound message |
| rxData | output | 256 | Inbound message bytes |
| rxReplyValid | input | 1 | Consumer supplies its reply |
| rxReplyData | input | 256 | Reply to write back to the inbound buffer |
| irqSendDone | input | 1 | Co-processor notification: outbound work finished |
| irqRecvNew | input | 1 | Co-processor notification: new inbound messages |
| doorbell | output | 1 | One-cycle pulse to the co-processor |
| ramAddr | output | 10 | Shared RAM address |
| ramWe | output | 1 | Shared RAM write enable |
| ramWdata | output | 8 | Shared RAM write data |
| ramRdata | input | 8 | Shared RAM read data, valid one cycle after the address |

## Verification
The bench models the co-processor and goes after the following cases.
- A message offered while the outbound mailbox is still NEW or RCVD. An engine that skipped the IDLE check would overwrite a buffer the co-processor is still reading.
- A held message that must follow the IDLE write of a completion. Without this, the message would be stranded until the next offer.
- A completion on a channel with nothing in flight. A careless design would invent a reply.
- Two outbound channels finishing in one sweep, plus both notifications arriving in the same cycle. A wrong scan order or priority shows up as replies and inbound messages out of sequence in the scoreboard.
- On the inbound side, a claimed channel and an unclaimed one. The bench checks that the unclaimed buffer is left intact, and that the engine never returns a mailbox to IDLE by itself.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

  localparam logic [7:0] MB_IDLE = 8'd0;
  localparam logic [7:0] MB_NEW  = 8'd1;
  localparam logic [7:0] MB_RCVD = 8'd2;
  localparam logic [7:0] MB_DONE = 8'd3;

  typedef enum logic [1:0] {
    AK_SEND_ST,
    AK_RECV_ST,
    AK_SEND_BUF,
    AK_RECV_BUF
  } addrKind_t;

  typedef enum logic [1:0] {
    RO_NONE,
    RO_READ,
    RO_WR_STATE,
    RO_WR_BYTE
  } ramOp_t;

  typedef struct packed {
    ramOp_t     op;
    addrKind_t  kind;
    logic [7:0] stateVal;
    logic       loadPend;
    logic       loadReply;
    logic       shiftTx;
    logic       shiftRx;
  } dpStrobe_t;

endpackage

// File: rtl/mbx_datapath.sv
module mbx_datapath
  import mbx_pkg::*;
#(
  parameter int NUM_CHAN        = 7,
  parameter int MSG_BYTES       = 32,
  parameter int ADDR_W          = 10,
  parameter int CHW             = 3,
  parameter int IDXW            = 5,
  parameter int SEND_BUF_BASE   = 0,
  parameter int RECV_BUF_BASE   = 256,
  parameter int SEND_STATE_BASE = 512,
  parameter int RECV_STATE_BASE = 520,
  localparam int MSG_W          = MSG_BYTES * 8
) (
  input  logic              clk,
  input  dpStrobe_t         strb,
  input  logic [CHW-1:0]    curChan,
  input  logic [IDXW-1:0]   byteIdx,
  input  logic              sendAccept,
  input  logic [CHW-1:0]    sendChan,
  input  logic [MSG_W-1:0]  sendData,
  input  logic [MSG_W-1:0]  rxReplyData,
  input  logic [7:0]        ramRdata,
  output logic [ADDR_W-1:0] ramAddr,
  output logic              ramWe,
  output logic [7:0]        ramWdata,
  output logic [MSG_W-1:0]  msgData
);

  logic [MSG_W-1:0] pendData [NUM_CHAN];
  logic [MSG_W-1:0] pendSel;
  logic [MSG_W-1:0] txReg;
  logic [MSG_W-1:0] msgReg;
  logic [ADDR_W-1:0] bufOffset;

  // one holding register per channel
  for (genvar ch = 0; ch < NUM_CHAN; ch++) begin : g_hold
    always_ff @(posedge clk) begin
      if (sendAccept && sendChan == CHW'(ch)) pendData[ch] <= sendData;
    end
  end

  always_comb begin
    pendSel = '0;
    for (int i = 0; i < NUM_CHAN; i++) begin
      if (curChan == CHW'(i)) pendSel = pendData[i];
    end
  end

  // outbound byte stream: byte 0 leaves first
  always_ff @(posedge clk) begin
    if (strb.loadPend)       txReg <= pendSel;
    else if (strb.loadReply) txReg <= rxReplyData;
    else if (strb.shiftTx)   txReg <= txReg >> 8;
  end

  // inbound byte stream: byte 0 ends in the low byte
  always_ff @(posedge clk) begin
    if (strb.shiftRx) msgReg <= {ramRdata, msgReg[MSG_W-1:8]};
  end

  assign msgData   = msgReg;
  assign bufOffset = ADDR_W'(curChan) * ADDR_W'(MSG_BYTES) + ADDR_W'(byteIdx);

  always_comb begin
    unique case (strb.kind)
      AK_SEND_ST:  ramAddr = ADDR_W'(SEND_STATE_BASE) + ADDR_W'(curChan);
      AK_RECV_ST:  ramAddr = ADDR_W'(RECV_STATE_BASE) + ADDR_W'(curChan);
      AK_SEND_BUF: ramAddr = ADDR_W'(SEND_BUF_BASE) + bufOffset;
      default:     ramAddr = ADDR_W'(RECV_BUF_BASE) + bufOffset;
    endcase
  end

  assign ramWe    = (strb.op == RO_WR_STATE) || (strb.op == RO_WR_BYTE);
  assign ramWdata = (strb.op == RO_WR_STATE) ? strb.stateVal : txReg[7:0];

endmodule

// File: rtl/mbx_ctrl.sv
module mbx_ctrl
  import mbx_pkg::*;
#(
  parameter int NUM_CHAN  = 7,
  parameter int MSG_BYTES = 32,
  parameter int CHW       = 3,
  parameter int IDXW      = 5
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                irqSend,
  input  logic                irqRecv,
  input  logic                sendValid,
  input  logic [CHW-1:0]      sendChan,
  input  logic [NUM_CHAN-1:0] rxClaim,
  input  logic                rxReplyValid,
  input  logic [7:0]          stateRd,
  output dpStrobe_t           strb,
  output logic [CHW-1:0]      curChan,
  output logic [IDXW-1:0]     byteIdx,
  output logic                sendAccept,
  output logic                sendBusy,
  output logic                doorbell,
  output logic                replyValid,
  output logic                rxValid
);

  typedef enum logic [3:0] {
    S_IDLE, S_ST_RD, S_ST_CHK, S_RD_BUF, S_RD_TAIL, S_WR_IDLE,
    S_WR_RCVD, S_WAIT, S_WR_BUF, S_WR_FINAL, S_BELL, S_NEXT
  } fsm_t;

  typedef enum logic [1:0] { MD_SEND_SCAN, MD_RECV_SCAN, MD_TRY } mode_t;

  localparam logic [IDXW-1:0] LAST_IDX  = IDXW'(MSG_BYTES - 1);
  localparam logic [CHW-1:0]  LAST_CHAN = CHW'(NUM_CHAN - 1);

  fsm_t  st_q, stNext;
  mode_t mode_q, modeNext;
  logic [CHW-1:0]  chan_q, chanNext;
  logic [IDXW-1:0] idx_q, idxNext;
  logic [NUM_CHAN-1:0] pendValid_q, pendTry_q, inFlight_q;
  logic int0Pend_q, int1Pend_q;
  logic take0, take1, sendCur, clrTryCur, clrFlightCur;
  logic curPend, curClaim, curFlight, anyTry, isRecv;
  logic [CHW-1:0] firstTry;

  assign isRecv = (mode_q == MD_RECV_SCAN);

  always_comb begin
    curPend = 1'b0; curClaim = 1'b0; curFlight = 1'b0;
    for (int i = 0; i < NUM_CHAN; i++) begin
      if (chan_q == CHW'(i)) begin
        curPend   = pendValid_q[i];
        curClaim  = rxClaim[i];
        curFlight = inFlight_q[i];
      end
    end
  end

  always_comb begin
    firstTry = '0;
    for (int i = NUM_CHAN - 1; i >= 0; i--) begin
      if (pendTry_q[i]) firstTry = CHW'(i);
    end
  end
  assign anyTry = |pendTry_q;

  always_comb begin
    sendBusy = 1'b1;
    for (int i = 0; i < NUM_CHAN; i++) begin
      if (sendChan == CHW'(i)) sendBusy = pendValid_q[i];
    end
  end
  assign sendAccept = sendValid && !sendBusy;

  always_comb begin
    stNext = st_q; modeNext = mode_q; chanNext = chan_q; idxNext = idx_q;
    strb = '{op: RO_NONE, kind: AK_SEND_ST, stateVal: MB_IDLE,
             loadPend: 1'b0, loadReply: 1'b0, shiftTx: 1'b0, shiftRx: 1'b0};
    take0 = 1'b0; take1 = 1'b0; sendCur = 1'b0; clrTryCur = 1'b0; clrFlightCur = 1'b0;
    doorbell = 1'b0; replyValid = 1'b0; rxValid = 1'b0;
    unique case (st_q)
      S_IDLE: begin
        chanNext = '0;
        if (int0Pend_q) begin
          take0 = 1'b1; modeNext = MD_SEND_SCAN; stNext = S_ST_RD;
        end else if (int1Pend_q) begin
          take1 = 1'b1; modeNext = MD_RECV_SCAN; stNext = S_ST_RD;
        end else if (anyTry) begin
          modeNext = MD_TRY; chanNext = firstTry; stNext = S_ST_RD;
        end
      end
      S_ST_RD: begin
        strb.op = RO_READ;
        strb.kind = isRecv ? AK_RECV_ST : AK_SEND_ST;
        stNext = S_ST_CHK;
      end
      S_ST_CHK: begin
        idxNext = '0;
        unique case (mode_q)
          MD_SEND_SCAN: stNext = (stateRd == MB_DONE) ? S_RD_BUF : S_NEXT;
          MD_RECV_SCAN: stNext = (stateRd == MB_NEW)  ? S_RD_BUF : S_NEXT;
          default: begin
            clrTryCur = 1'b1;
            if (stateRd == MB_IDLE) begin
              strb.loadPend = 1'b1; sendCur = 1'b1; stNext = S_WR_BUF;
            end else begin
              stNext = S_IDLE;
            end
          end
        endcase
      end
      S_RD_BUF: begin
        strb.op = RO_READ;
        strb.kind = isRecv ? AK_RECV_BUF : AK_SEND_BUF;
        strb.shiftRx = (idx_q != '0);
        idxNext = idx_q + 1'b1;
        if (idx_q == LAST_IDX) stNext = S_RD_TAIL;
      end
      S_RD_TAIL: begin
        strb.shiftRx = 1'b1;
        stNext = isRecv ? S_WR_RCVD : S_WR_IDLE;
      end
      S_WR_IDLE: begin
        strb.op = RO_WR_STATE; strb.kind = AK_SEND_ST; strb.stateVal = MB_IDLE;
        replyValid = curFlight;
        clrFlightCur = 1'b1;
        idxNext = '0;
        if (curPend) begin
          strb.loadPend = 1'b1; sendCur = 1'b1; stNext = S_WR_BUF;
        end else begin
          stNext = S_NEXT;
        end
      end
      S_WR_RCVD: begin
        strb.op = RO_WR_STATE; strb.kind = AK_RECV_ST; strb.stateVal = MB_RCVD;
        rxValid = curClaim;
        idxNext = '0;
        stNext = curClaim ? S_WAIT : S_WR_FINAL;
      end
      S_WAIT: begin
        strb.loadReply = rxReplyValid;
        if (rxReplyValid) stNext = S_WR_BUF;
      end
      S_WR_BUF: begin
        strb.op = RO_WR_BYTE;
        strb.kind = isRecv ? AK_RECV_BUF : AK_SEND_BUF;
        strb.shiftTx = 1'b1;
        idxNext = idx_q + 1'b1;
        if (idx_q == LAST_IDX) stNext = S_WR_FINAL;
      end
      S_WR_FINAL: begin
        strb.op = RO_WR_STATE;
        strb.kind = isRecv ? AK_RECV_ST : AK_SEND_ST;
        strb.stateVal = isRecv ? MB_DONE : MB_NEW;
        stNext = S_BELL;
      end
      S_BELL: begin
        doorbell = 1'b1;
        stNext = (mode_q == MD_TRY) ? S_IDLE : S_NEXT;
      end
      default: begin
        if (chan_q == LAST_CHAN) begin
          stNext = S_IDLE;
        end else begin
          chanNext = chan_q + 1'b1;
          stNext = S_ST_RD;
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      st_q <= S_IDLE; mode_q <= MD_SEND_SCAN; chan_q <= '0; idx_q <= '0;
      int0Pend_q <= 1'b0; int1Pend_q <= 1'b0;
      pendValid_q <= '0; pendTry_q <= '0; inFlight_q <= '0;
    end else begin
      st_q <= stNext; mode_q <= modeNext; chan_q <= chanNext; idx_q <= idxNext;
      int0Pend_q <= (int0Pend_q && !take0) || irqSend;
      int1Pend_q <= (int1Pend_q && !take1) || irqRecv;
      for (int i = 0; i < NUM_CHAN; i++) begin
        if (chan_q == CHW'(i)) begin
          if (clrTryCur)    pendTry_q[i]  <= 1'b0;
          if (clrFlightCur) inFlight_q[i] <= 1'b0;
          if (sendCur) begin
            pendValid_q[i] <= 1'b0;
            pendTry_q[i]   <= 1'b0;
            inFlight_q[i]  <= 1'b1;
          end
        end
        if (sendAccept && sendChan == CHW'(i)) begin
          pendValid_q[i] <= 1'b1;
          pendTry_q[i]   <= 1'b1;
        end
      end
    end
  end

  assign curChan = chan_q;
  assign byteIdx = idx_q;

  // a held message only leaves through the send step
  AST_HOLD_CLEARED_BY_SEND: assert property (@(posedge clk) disable iff (!rstN)
    ($countones(pendValid_q) < $countones($past(pendValid_q))) |-> $past(sendCur)); // R4

endmodule

// File: rtl/mbx_engine.sv
module mbx_engine
  import mbx_pkg::*;
#(
  parameter int NUM_CHAN        = 7,
  parameter int MSG_BYTES       = 32,
  parameter int ADDR_W          = 10,
  parameter int SEND_BUF_BASE   = 0,
  parameter int RECV_BUF_BASE   = 256,
  parameter int SEND_STATE_BASE = 512,
  parameter int RECV_STATE_BASE = 520,
  localparam int MSG_W          = MSG_BYTES * 8,
  localparam int CHW            = (NUM_CHAN > 1) ? $clog2(NUM_CHAN) : 1,
  localparam int IDXW           = $clog2(MSG_BYTES)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                sendValid,
  input  logic [CHW-1:0]      sendChan,
  input  logic [MSG_W-1:0]    sendData,
  output logic                sendBusy,
  output logic                replyValid,
  output logic [CHW-1:0]      replyChan,
  output logic [MSG_W-1:0]    replyData,
  input  logic [NUM_CHAN-1:0] rxClaim,
  output logic                rxValid,
  output logic [CHW-1:0]      rxChan,
  output logic [MSG_W-1:0]    rxData,
  input  logic                rxReplyValid,
  input  logic [MSG_W-1:0]    rxReplyData,
  input  logic                irqSendDone,
  input  logic                irqRecvNew,
  output logic                doorbell,
  output logic [ADDR_W-1:0]   ramAddr,
  output logic                ramWe,
  output logic [7:0]          ramWdata,
  input  logic [7:0]          ramRdata
);

  dpStrobe_t        strb;
  logic [CHW-1:0]   curChan;
  logic [IDXW-1:0]  byteIdx;
  logic             sendAccept;
  logic [MSG_W-1:0] msgData;

  mbx_ctrl #(
    .NUM_CHAN(NUM_CHAN), .MSG_BYTES(MSG_BYTES), .CHW(CHW), .IDXW(IDXW)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .irqSend(irqSendDone), .irqRecv(irqRecvNew),
    .sendValid(sendValid), .sendChan(sendChan), .rxClaim(rxClaim),
    .rxReplyValid(rxReplyValid), .stateRd(ramRdata), .strb(strb),
    .curChan(curChan), .byteIdx(byteIdx), .sendAccept(sendAccept),
    .sendBusy(sendBusy), .doorbell(doorbell), .replyValid(replyValid),
    .rxValid(rxValid)
  );

  mbx_datapath #(
    .NUM_CHAN(NUM_CHAN), .MSG_BYTES(MSG_BYTES), .ADDR_W(ADDR_W), .CHW(CHW),
    .IDXW(IDXW), .SEND_BUF_BASE(SEND_BUF_BASE), .RECV_BUF_BASE(RECV_BUF_BASE),
    .SEND_STATE_BASE(SEND_STATE_BASE), .RECV_STATE_BASE(RECV_STATE_BASE)
  ) u_dp (
    .clk(clk), .strb(strb), .curChan(curChan), .byteIdx(byteIdx),
    .sendAccept(sendAccept), .sendChan(sendChan), .sendData(sendData),
    .rxReplyData(rxReplyData), .ramRdata(ramRdata), .ramAddr(ramAddr),
    .ramWe(ramWe), .ramWdata(ramWdata), .msgData(msgData)
  );

  assign replyChan = curChan;
  assign rxChan    = curChan;
  assign replyData = msgData;
  assign rxData    = msgData;

  AST_BELL_AFTER_MARK: assert property (@(posedge clk) disable iff (!rstN)
    doorbell |-> ($past(ramWe) && ($past(ramWdata) == MB_NEW || $past(ramWdata) == MB_DONE))); // R2
  AST_RECV_NEVER_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (ramWe && ramAddr >= ADDR_W'(RECV_STATE_BASE) && ramAddr < ADDR_W'(RECV_STATE_BASE + NUM_CHAN))
      |-> (ramWdata != MB_IDLE)); // R9
  AST_REPLY_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    replyValid |=> !replyValid); // R3
  AST_RX_THEN_WAIT: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |=> (!ramWe && !rxValid)); // R7

endmodule

// File: tb/tb_mbx_engine.sv
`timescale 1ns/1ps
module tb_mbx_engine;

  localparam int SB = 0, RB = 256, SS = 512, RS = 520;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sendValid = 1'b0;
  logic [2:0] sendChan = '0;
  logic [255:0] sendData = '0;
  logic sendBusy, replyValid, rxValid, doorbell, ramWe;
  logic [2:0] replyChan, rxChan;
  logic [255:0] replyData, rxData;
  logic [6:0] rxClaim = '0;
  logic rxReplyValid = 1'b0;
  logic [255:0] rxReplyData = '0;
  logic irqSendDone = 1'b0, irqRecvNew = 1'b0;
  logic [9:0] ramAddr;
  logic [7:0] ramWdata, ramRdata;

  logic [7:0] mem [0:1023];
  logic tbWe = 1'b0;
  logic [9:0] tbAddr = '0;
  logic [7:0] tbData = '0;

  int checks = 0, errors = 0, bellCnt = 0;

  typedef struct { bit isRx; int chan; logic [255:0] data; } item_t;
  item_t expQ[$];

  always #2.5 clk = ~clk;

  mbx_engine dut (
    .clk(clk), .rstN(rstN), .sendValid(sendValid), .sendChan(sendChan),
    .sendData(sendData), .sendBusy(sendBusy), .replyValid(replyValid),
    .replyChan(replyChan), .replyData(replyData), .rxClaim(rxClaim),
    .rxValid(rxValid), .rxChan(rxChan), .rxData(rxData),
    .rxReplyValid(rxReplyValid), .rxReplyData(rxReplyData),
    .irqSendDone(irqSendDone), .irqRecvNew(irqRecvNew), .doorbell(doorbell),
    .ramAddr(ramAddr), .ramWe(ramWe), .ramWdata(ramWdata), .ramRdata(ramRdata)
  );

  // shared RAM with a co-processor write port
  always @(posedge clk) begin
    if (ramWe) mem[ramAddr] <= ramWdata;
    else if (tbWe) mem[tbAddr] <= tbData;
    ramRdata <= mem[ramAddr];
  end

  task automatic chk(input string req, input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rstN) begin
      if (doorbell) bellCnt++;
      if (replyValid || rxValid) begin
        if (expQ.size() == 0) begin
          chk(replyValid ? "R11 unexpected reply" : "R8 unexpected rx", 256'(replyChan), 256'hFF);
        end else begin
          item_t it;
          it = expQ.pop_front();
          chk("R10 item kind", 256'(rxValid), 256'(it.isRx));
          chk("R6 item chan", 256'(rxValid ? rxChan : replyChan), 256'(it.chan));
          chk(it.isRx ? "R7 rx data" : "R3 reply data", rxValid ? rxData : replyData, it.data);
        end
      end
    end
  end

  function automatic logic [255:0] mkMsg(input int seed);
    logic [255:0] m;
    for (int i = 0; i < 32; i++) m[i*8 +: 8] = 8'(seed * 37 + i * 11 + 5);
    return m;
  endfunction

  function automatic logic [255:0] bufAt(input int base, input int ch);
    logic [255:0] r;
    for (int i = 0; i < 32; i++) r[i*8 +: 8] = mem[base + ch * 32 + i];
    return r;
  endfunction

  task automatic poke(input int addr, input logic [7:0] d);
    @(negedge clk); tbAddr = 10'(addr); tbData = d; tbWe = 1'b1;
    @(negedge clk); tbWe = 1'b0;
  endtask

  task automatic pokeMsg(input int base, input int ch, input logic [255:0] m);
    for (int i = 0; i < 32; i++) poke(base + ch * 32 + i, m[i*8 +: 8]);
  endtask

  task automatic offer(input int ch, input logic [255:0] m);
    @(negedge clk); sendChan = 3'(ch); sendData = m; sendValid = 1'b1;
    @(negedge clk); sendValid = 1'b0;
  endtask

  task automatic pulse(input bit s, input bit r);
    @(negedge clk); irqSendDone = s; irqRecvNew = r;
    @(negedge clk); irqSendDone = 1'b0; irqRecvNew = 1'b0;
  endtask

  task automatic expectItem(input bit isRx, input int ch, input logic [255:0] d);
    item_t it;
    it.isRx = isRx; it.chan = ch; it.data = d;
    expQ.push_back(it);
  endtask

  task automatic settle();
    repeat (700) @(negedge clk);
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int b;
    repeat (3) @(negedge clk);
    for (int c = 0; c < 7; c++) begin poke(SS + c, 8'd0); poke(RS + c, 8'd0); end
    // R1 reset state
    chk("R1 doorbell", 256'(doorbell), 0);
    chk("R1 replyValid", 256'(replyValid), 0);
    chk("R1 rxValid", 256'(rxValid), 0);
    chk("R1 ramWe", 256'(ramWe), 0);
    chk("R1 sendBusy", 256'(sendBusy), 0);
    @(negedge clk); rstN = 1'b1;
    @(negedge clk);
    chk("R1 after reset ramWe", 256'(ramWe), 0);

    // R2 basic send on channel 2
    offer(2, mkMsg(1)); settle();
    chk("R2 buffer", bufAt(SB, 2), mkMsg(1));
    chk("R2 state NEW", 256'(mem[SS + 2]), 1);
    chk("R2 doorbell count", 256'(bellCnt), 1);

    // R4/R5 second message held while mailbox busy
    @(negedge clk); sendChan = 3'd2;
    chk("R5 not busy before hold", 256'(sendBusy), 0);
    offer(2, mkMsg(2)); settle();
    chk("R4 buffer untouched", bufAt(SB, 2), mkMsg(1));
    chk("R4 no extra doorbell", 256'(bellCnt), 1);
    sendChan = 3'd2; @(negedge clk);
    chk("R5 busy when full", 256'(sendBusy), 1);
    offer(2, mkMsg(3));
    sendChan = 3'd7; @(negedge clk);
    chk("R5 busy on invalid channel", 256'(sendBusy), 1);

    // R3/R4 completion with held message behind it
    pokeMsg(SB, 2, mkMsg(20)); poke(SS + 2, 8'd3);
    expectItem(0, 2, mkMsg(20));
    pulse(1, 0); settle();
    chk("R4 held message sent", bufAt(SB, 2), mkMsg(2));
    chk("R4 state NEW again", 256'(mem[SS + 2]), 1);
    chk("R4 doorbell count", 256'(bellCnt), 2);
    sendChan = 3'd2; @(negedge clk);
    chk("R5 ignored request left slot free", 256'(sendBusy), 0);
    pokeMsg(SB, 2, mkMsg(21)); poke(SS + 2, 8'd3);
    expectItem(0, 2, mkMsg(21));
    pulse(1, 0); settle();
    chk("R3 state IDLE", 256'(mem[SS + 2]), 0);
    chk("R5 ignored request never sent", 256'(bellCnt), 2);

    // R6 two channels in one sweep, offered in reverse order
    offer(5, mkMsg(5)); settle();
    offer(1, mkMsg(6)); settle();
    chk("R2 second channel buffer", bufAt(SB, 1), mkMsg(6));
    pokeMsg(SB, 5, mkMsg(30)); pokeMsg(SB, 1, mkMsg(31));
    poke(SS + 5, 8'd3); poke(SS + 1, 8'd3);
    expectItem(0, 1, mkMsg(31)); expectItem(0, 5, mkMsg(30));
    pulse(1, 0); settle();
    chk("R6 both idle", 256'({mem[SS + 1], mem[SS + 5]}), 0);

    // R8/R9 unclaimed inbound message
    b = bellCnt;
    pokeMsg(RB, 3, mkMsg(40)); poke(RS + 3, 8'd1);
    pulse(0, 1); settle();
    chk("R8 state COMPLETE", 256'(mem[RS + 3]), 3);
    chk("R8 buffer untouched", bufAt(RB, 3), mkMsg(40));
    chk("R8 doorbell", 256'(bellCnt), 256'(b + 1));
    pulse(0, 1); settle();
    chk("R9 state left for co-processor", 256'(mem[RS + 3]), 3);

    // R7 claimed inbound message
    rxClaim[4] = 1'b1; b = bellCnt;
    pokeMsg(RB, 4, mkMsg(50)); poke(RS + 4, 8'd1);
    expectItem(1, 4, mkMsg(50));
    pulse(0, 1); settle();
    chk("R7 state RCVD while waiting", 256'(mem[RS + 4]), 2);
    @(negedge clk); rxReplyData = mkMsg(51); rxReplyValid = 1'b1;
    @(negedge clk); rxReplyValid = 1'b0;
    settle();
    chk("R7 reply written", bufAt(RB, 4), mkMsg(51));
    chk("R7 state COMPLETE", 256'(mem[RS + 4]), 3);
    chk("R7 doorbell", 256'(bellCnt), 256'(b + 1));

    // R4 offer while co-processor still owns mailbox
    poke(SS + 0, 8'd2); b = bellCnt;
    offer(0, mkMsg(60)); settle();
    chk("R4 not sent when RCVD", 256'(mem[SS + 0]), 2);
    chk("R4 no doorbell when RCVD", 256'(bellCnt), 256'(b));
    // R11 completion with nothing in flight releases the held message
    poke(SS + 0, 8'd3);
    pulse(1, 0); settle();
    chk("R11 held message sent", bufAt(SB, 0), mkMsg(60));
    chk("R11 state NEW", 256'(mem[SS + 0]), 1);

    // R10 both notifications together
    rxClaim[6] = 1'b1;
    pokeMsg(SB, 0, mkMsg(70)); poke(SS + 0, 8'd3);
    pokeMsg(RB, 6, mkMsg(71)); poke(RS + 6, 8'd1);
    expectItem(0, 0, mkMsg(70)); expectItem(1, 6, mkMsg(71));
    pulse(1, 1); settle();
    @(negedge clk); rxReplyData = mkMsg(72); rxReplyValid = 1'b1;
    @(negedge clk); rxReplyValid = 1'b0;
    settle();
    chk("R10 inbound finished", 256'(mem[RS + 6]), 3);
    chk("R3 R10 outbound idle", 256'(mem[SS + 0]), 0);
    chk("R6 scoreboard drained", 256'(expQ.size()), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule